// File: doc/BRIEF.md
# Multi-Source Chip Reset Controller

This block collects every reason a small processor core may need to restart and turns them into a single chip reset, synchronous to the core clock. The sources are power-on, a low level on the external reset pin, a watchdog timeout, a brown-out (only when its enable is set), the software reset instruction, and stack overflow or underflow. The power-on, brown-out and pin requests are asynchronous and each passes through a two-flop synchroniser. The pin request must then stay low for a set number of samples before it counts.

A power-on or an enabled brown-out holds the chip in reset. When the request goes away, up to two start-up timers run one after the other: a power-up delay and then an oscillator settle delay. Each timer has its own enable. Requests from software, the stack and the watchdog give a short reset pulse of fixed length and do not restart the timers. A watchdog timeout while the core sleeps does not reset the chip. It gives a one-cycle wake pulse instead.

Five status flags record what happened. Each flag is cleared by its own event, and software can set some of them again. Software reads the flags to find the cause of the last restart.

Top module: `chip_reset_ctrl`

## Requirements
- R1: While the synchronised power-on request is high, `chip_rst_o` is high. On the first cycle after it falls, `flags_o` reads 5'b11100, with bit 4 = swr_n, bit 3 = wdg_n, bit 2 = slp_n, bit 1 = pon_n, bit 0 = brn_n.
- R2: After a power-on or brown-out request ends, reset stays high for 2**TIMER_W cycles for each enabled start-up timer, power-up timer first. With both timers disabled, reset drops within a few cycles.
- R3: When `bo_en_i` is high, a brown-out holds reset, runs the enabled timers and clears brn_n. When `bo_en_i` is low, a brown-out has no effect on reset or on the flags.
- R4: A pin low for fewer than FILT_LEN (4) consecutive synchronised samples is ignored. A longer low holds reset until the pin goes high again, and the start-up timers do not run.
- R5: A valid pin reset that begins while `sleep_i` is high sets wdg_n and clears slp_n.
- R6: A one-cycle `sw_rst_i` gives a reset pulse of exactly PULSE_LEN (2) cycles and clears swr_n.
- R7: A one-cycle stack-full or stack-underflow request gives a 2-cycle reset pulse and leaves the flags unchanged.
- R8: A watchdog timeout with `sleep_i` low gives a 2-cycle reset pulse and clears wdg_n.
- R9: A watchdog timeout with `sleep_i` high gives no reset, a one-cycle `wake_o` pulse, and clears wdg_n and slp_n.
- R10: A rising edge on `sleep_i` clears slp_n.
- R11: `flag_set_i` bits 2, 1 and 0 set swr_n, pon_n and brn_n. A clearing event in the same cycle wins over the set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_req_i | input | 1 | Power-on detector request, asynchronous, active high |
| pin_n_i | input | 1 | External reset pin, asynchronous, active low |
| brownout_i | input | 1 | Brown-out detector request, asynchronous, active high |
| bo_en_i | input | 1 | Allows brown-out to cause a reset |
| pwrup_tmr_en_i | input | 1 | Enables the power-up delay timer |
| osc_tmr_en_i | input | 1 | Enables the oscillator settle timer |
| sw_rst_i | input | 1 | Software reset instruction, one-cycle pulse |
| stk_full_i | input | 1 | Stack overflow, one-cycle pulse |
| stk_under_i | input | 1 | Stack underflow, one-cycle pulse |
| wdt_timeout_i | input | 1 | Watchdog timeout, one-cycle pulse |
| sleep_i | input | 1 | Core is in sleep mode |
| flag_set_i | input | 3 | Software set strobes for swr_n, pon_n, brn_n |
| chip_rst_o | output | 1 | Chip reset, active high |
| wake_o | output | 1 | Wake-from-sleep pulse caused by the watchdog |
| flags_o | output | 5 | Status flags {swr_n, wdg_n, slp_n, pon_n, brn_n} |

## Verification
If the start-up sequencer gets stuck or skips a phase, the length of the reset after power-on or brown-out changes by a whole timer period of 2**TIMER_W cycles. The bench sees this as soon as reset falls. If the pin filter counter is wrong, a 3-sample glitch causes a reset, or a long low gives a reset of the wrong length, and this shows within about ten cycles. Errors in the pulse counter or in the flag update rules show in the first few cycles after the triggering request, as a reset pulse of the wrong length or a wrong bit in `flags_o`.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef struct packed {
        logic swr_n;
        logic wdg_n;
        logic slp_n;
        logic pon_n;
        logic brn_n;
    } rst_flags_t;

    typedef enum logic [1:0] {
        SEQ_HOLD,
        SEQ_PWRUP,
        SEQ_OSC,
        SEQ_DONE
    } seq_state_e;

    localparam rst_flags_t FLAGS_AT_POWERON = '{
        swr_n: 1'b1, wdg_n: 1'b1, slp_n: 1'b1, pon_n: 1'b0, brn_n: 1'b0
    };

    // first timer phase after a hold, given the enables
    function automatic seq_state_e seq_first(input logic pwrup_en, input logic osc_en);
        if (pwrup_en)    return SEQ_PWRUP;
        else if (osc_en) return SEQ_OSC;
        else             return SEQ_DONE;
    endfunction

endpackage

// File: rtl/rstc_sync2.sv
module rstc_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        meta_q <= d_i;
        sync_q <= meta_q;
    end

    assign q_o = sync_q;
endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic clr_i,
    input  logic low_i,
    output logic valid_o
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(LEN);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (clr_i || !low_i)
            run_q <= '0;
        else if (run_q != FULL)
            run_q <= run_q + CW'(1);
    end

    assign valid_o = (run_q == FULL);
endmodule

// File: rtl/rstc_startup_seq.sv
module rstc_startup_seq
    import rstc_pkg::*;
#(
    parameter int TIMER_W = 10
) (
    input  logic clk,
    input  logic hold_i,
    input  logic pwrup_en_i,
    input  logic osc_en_i,
    output logic busy_o
);
    localparam logic [TIMER_W-1:0] TERM = '1;

    seq_state_e            st_q;
    logic [TIMER_W-1:0]    tmr_q;

    always_ff @(posedge clk) begin
        if (hold_i) begin
            st_q  <= SEQ_HOLD;
            tmr_q <= '0;
        end else begin
            case (st_q)
                SEQ_HOLD: begin
                    st_q  <= seq_first(pwrup_en_i, osc_en_i);
                    tmr_q <= '0;
                end
                SEQ_PWRUP: begin
                    tmr_q <= tmr_q + TIMER_W'(1);
                    if (tmr_q == TERM)
                        st_q <= osc_en_i ? SEQ_OSC : SEQ_DONE;
                end
                SEQ_OSC: begin
                    tmr_q <= tmr_q + TIMER_W'(1);
                    if (tmr_q == TERM)
                        st_q <= SEQ_DONE;
                end
                default: ;
            endcase
        end
    end

    assign busy_o = (st_q != SEQ_DONE);
endmodule

// File: rtl/chip_reset_ctrl.sv
module chip_reset_ctrl
    import rstc_pkg::*;
#(
    parameter int TIMER_W   = 10,
    parameter int FILT_LEN  = 4,
    parameter int PULSE_LEN = 2
) (
    input  logic       clk,
    input  logic       por_req_i,
    input  logic       pin_n_i,
    input  logic       brownout_i,
    input  logic       bo_en_i,
    input  logic       pwrup_tmr_en_i,
    input  logic       osc_tmr_en_i,
    input  logic       sw_rst_i,
    input  logic       stk_full_i,
    input  logic       stk_under_i,
    input  logic       wdt_timeout_i,
    input  logic       sleep_i,
    input  logic [2:0] flag_set_i,
    output logic       chip_rst_o,
    output logic       wake_o,
    output logic [4:0] flags_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic por_s, bod_s, pin_low_s;
    logic bor_evt, hold, seq_busy;
    logic pin_valid, pin_valid_q;
    logic short_evt, sleep_q, wake_q;
    logic [PW-1:0] pulse_q;
    rst_flags_t flags_q;

    rstc_sync2 #(.W(3)) u_sync (
        .clk (clk),
        .d_i ({por_req_i, brownout_i, ~pin_n_i}),
        .q_o ({por_s, bod_s, pin_low_s})
    );

    rstc_pin_filter #(.LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .clr_i   (por_s),
        .low_i   (pin_low_s),
        .valid_o (pin_valid)
    );

    assign bor_evt = bod_s & bo_en_i;
    assign hold    = por_s | bor_evt;

    rstc_startup_seq #(.TIMER_W(TIMER_W)) u_seq (
        .clk        (clk),
        .hold_i     (hold),
        .pwrup_en_i (pwrup_tmr_en_i),
        .osc_en_i   (osc_tmr_en_i),
        .busy_o     (seq_busy)
    );

    assign short_evt = sw_rst_i | stk_full_i | stk_under_i | (wdt_timeout_i & ~sleep_i);

    always_ff @(posedge clk) begin
        if (por_s)
            pulse_q <= '0;
        else if (short_evt)
            pulse_q <= PW'(PULSE_LEN);
        else if (pulse_q != '0)
            pulse_q <= pulse_q - PW'(1);
    end

    always_ff @(posedge clk) begin
        if (por_s) begin
            flags_q     <= FLAGS_AT_POWERON;
            sleep_q     <= 1'b0;
            pin_valid_q <= 1'b0;
            wake_q      <= 1'b0;
        end else begin
            sleep_q     <= sleep_i;
            pin_valid_q <= pin_valid;
            wake_q      <= wdt_timeout_i & sleep_i;
            // software sets first; events below override them
            if (flag_set_i[2]) flags_q.swr_n <= 1'b1;
            if (flag_set_i[1]) flags_q.pon_n <= 1'b1;
            if (flag_set_i[0]) flags_q.brn_n <= 1'b1;
            if (bor_evt)       flags_q.brn_n <= 1'b0;
            if (sw_rst_i)      flags_q.swr_n <= 1'b0;
            if (sleep_i && !sleep_q) flags_q.slp_n <= 1'b0;
            if (pin_valid && !pin_valid_q && sleep_i) begin
                flags_q.wdg_n <= 1'b1;
                flags_q.slp_n <= 1'b0;
            end
            if (wdt_timeout_i) begin
                flags_q.wdg_n <= 1'b0;
                if (sleep_i) flags_q.slp_n <= 1'b0;
            end
        end
    end

    assign chip_rst_o = seq_busy | pin_valid | (pulse_q != '0);
    assign wake_o     = wake_q;
    assign flags_o    = flags_q;
endmodule

// File: rtl/chip_reset_ctrl_chk.sv
module chip_reset_ctrl_chk (
    input logic       clk,
    input logic       por_s,
    input logic       bod_s,
    input logic       bo_en_i,
    input logic       sw_rst_i,
    input logic       stk_full_i,
    input logic       stk_under_i,
    input logic       wdt_timeout_i,
    input logic       sleep_i,
    input logic       chip_rst_o,
    input logic       wake_o,
    input logic [4:0] flags_o
);
    assert_poweron_flags_R1: assert property (@(posedge clk) disable iff (por_s)
        $fell(por_s) |-> (chip_rst_o && flags_o == 5'b11100));

    assert_brownout_hold_R3: assert property (@(posedge clk) disable iff (por_s)
        (bod_s && bo_en_i) |=> (chip_rst_o && !flags_o[0]));

    assert_sw_pulse_R6: assert property (@(posedge clk) disable iff (por_s)
        sw_rst_i |=> (chip_rst_o && !flags_o[4]) ##1 chip_rst_o);

    assert_stack_pulse_R7: assert property (@(posedge clk) disable iff (por_s)
        (stk_full_i || stk_under_i) |=> chip_rst_o ##1 chip_rst_o);

    assert_wdt_run_R8: assert property (@(posedge clk) disable iff (por_s)
        (wdt_timeout_i && !sleep_i) |=> (chip_rst_o && !flags_o[3]));

    assert_wdt_wake_R9: assert property (@(posedge clk) disable iff (por_s)
        (wdt_timeout_i && sleep_i) |=> (wake_o && !flags_o[3] && !flags_o[2]));

    assert_sleep_entry_R10: assert property (@(posedge clk) disable iff (por_s)
        $rose(sleep_i) |=> !flags_o[2]);
endmodule

bind chip_reset_ctrl chip_reset_ctrl_chk i_chk (
    .clk           (clk),
    .por_s         (por_s),
    .bod_s         (bod_s),
    .bo_en_i       (bo_en_i),
    .sw_rst_i      (sw_rst_i),
    .stk_full_i    (stk_full_i),
    .stk_under_i   (stk_under_i),
    .wdt_timeout_i (wdt_timeout_i),
    .sleep_i       (sleep_i),
    .chip_rst_o    (chip_rst_o),
    .wake_o        (wake_o),
    .flags_o       (flags_o)
);

// File: tb/test_chip_reset_ctrl.sv
`timescale 1ns/1ps
module test_chip_reset_ctrl;

    logic       clk = 1'b0;
    logic       por_req_i = 1'b1, pin_n_i = 1'b1, brownout_i = 1'b0, bo_en_i = 1'b0;
    logic       pwrup_tmr_en_i = 1'b1, osc_tmr_en_i = 1'b1;
    logic       sw_rst_i = 1'b0, stk_full_i = 1'b0, stk_under_i = 1'b0;
    logic       wdt_timeout_i = 1'b0, sleep_i = 1'b0;
    logic [2:0] flag_set_i = 3'b000;
    logic       chip_rst_o, wake_o;
    logic [4:0] flags_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [4:0] m;  // expected flags {swr_n, wdg_n, slp_n, pon_n, brn_n}

    always #2.5 clk = ~clk;

    chip_reset_ctrl i_chip_reset_ctrl (
        .clk(clk), .por_req_i(por_req_i), .pin_n_i(pin_n_i), .brownout_i(brownout_i),
        .bo_en_i(bo_en_i), .pwrup_tmr_en_i(pwrup_tmr_en_i), .osc_tmr_en_i(osc_tmr_en_i),
        .sw_rst_i(sw_rst_i), .stk_full_i(stk_full_i), .stk_under_i(stk_under_i),
        .wdt_timeout_i(wdt_timeout_i), .sleep_i(sleep_i), .flag_set_i(flag_set_i),
        .chip_rst_o(chip_rst_o), .wake_o(wake_o), .flags_o(flags_o)
    );

    typedef struct packed {
        logic       sw;
        logic       full;
        logic       under;
        logic       wdt;
        logic       slp;
        logic [2:0] rst_len;
        logic       wake;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3'd2, 1'b0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd2, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 3'd0, 1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 3'd2, 1'b0}
    };

    function automatic string req_of(vec_t v);
        if (v.sw)               return "R6";
        else if (v.wdt && v.slp) return "R9";
        else if (v.wdt)          return "R8";
        else                     return "R7";
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic check_range(string req, int act, int lo, int hi);
        checks++;
        if (act < lo || act > hi) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_rst(int n, inout int r, inout int w);
        repeat (n) begin
            @(negedge clk);
            r += int'(chip_rst_o);
            w += int'(wake_o);
        end
    endtask

    task automatic wait_release(int limit, output int n);
        n = 0;
        while (chip_rst_o && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL R2 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        int n, r, w;
        // reset state, R1
        cycles(6);
        check("R1", int'(chip_rst_o), 1);
        check("R1", int'(flags_o), 5'b11100);
        // both start-up timers, R2
        por_req_i = 1'b0;
        wait_release(3000, n);
        check_range("R2", n, 2048, 2056);
        check("R1", int'(flags_o), 5'b11100);

        // software set strobes, R11
        flag_set_i = 3'b111;
        cycles(1);
        flag_set_i = 3'b000;
        cycles(1);
        check("R11", int'(flags_o), 5'b11111);
        // set and clear in the same cycle: clear wins, R11
        flag_set_i = 3'b100; sw_rst_i = 1'b1;
        cycles(1);
        flag_set_i = 3'b000; sw_rst_i = 1'b0;
        cycles(4);
        check("R11", int'(flags_o[4]), 0);
        flag_set_i = 3'b100;
        cycles(1);
        flag_set_i = 3'b000;
        cycles(1);
        m = 5'b11111;

        // table of short reset sources and watchdog wake
        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            if (v.slp) begin
                sleep_i = 1'b1;
                m[2] = 1'b0;
                cycles(3);
                check("R10", int'(flags_o[2]), 0);
            end
            sw_rst_i = v.sw; stk_full_i = v.full; stk_under_i = v.under; wdt_timeout_i = v.wdt;
            cycles(1);
            sw_rst_i = 1'b0; stk_full_i = 1'b0; stk_under_i = 1'b0; wdt_timeout_i = 1'b0;
            r = int'(chip_rst_o);
            w = int'(wake_o);
            count_rst(7, r, w);
            check(req_of(v), r, int'(v.rst_len));
            check(req_of(v), w, int'(v.wake));
            if (v.sw)  m[4] = 1'b0;
            if (v.wdt) m[3] = 1'b0;
            if (v.wdt && v.slp) m[2] = 1'b0;
            check(req_of(v), int'(flags_o), int'(m));
            sleep_i = 1'b0;
            cycles(2);
        end

        // pin glitch of 3 samples ignored, R4
        r = 0; w = 0;
        pin_n_i = 1'b0;
        count_rst(3, r, w);
        pin_n_i = 1'b1;
        count_rst(12, r, w);
        check("R4", r, 0);
        check("R4", int'(flags_o), int'(m));
        // long pin low, R4
        r = 0;
        pin_n_i = 1'b0;
        count_rst(10, r, w);
        check_range("R4", r, 4, 6);
        pin_n_i = 1'b1;
        wait_release(3000, n);
        check_range("R4", n, 1, 4);

        // pin reset during sleep, R5
        sleep_i = 1'b1;
        m[2] = 1'b0;
        cycles(2);
        pin_n_i = 1'b0;
        cycles(10);
        pin_n_i = 1'b1;
        cycles(6);
        m[3] = 1'b1;
        check("R5", int'(flags_o), int'(m));
        sleep_i = 1'b0;
        cycles(2);

        // brown-out while disabled has no effect, R3
        r = 0; w = 0;
        bo_en_i = 1'b0;
        brownout_i = 1'b1;
        count_rst(6, r, w);
        brownout_i = 1'b0;
        count_rst(4, r, w);
        check("R3", r, 0);
        check("R3", int'(flags_o[0]), 1);
        // enabled brown-out with only the power-up timer, R3 and R2
        osc_tmr_en_i = 1'b0;
        bo_en_i = 1'b1;
        r = 0;
        brownout_i = 1'b1;
        count_rst(5, r, w);
        brownout_i = 1'b0;
        wait_release(3000, n);
        check_range("R3", r + n, 1024, 1034);
        check("R3", int'(flags_o[0]), 0);

        // power-on with both timers disabled, R2
        pwrup_tmr_en_i = 1'b0;
        por_req_i = 1'b1;
        cycles(4);
        por_req_i = 1'b0;
        wait_release(3000, n);
        check_range("R2", n, 1, 5);
        check("R1", int'(flags_o), 5'b11100);

        finish_run();
    end
endmodule